// File: doc/BRIEF.md
# Register-Port Cipher Engine Bridge

This block lets a processor drive two block-cipher engines through its 64-bit model-specific register read/write port, with no system-bus transaction. One engine takes a 128-bit key and a 128-bit block and finishes 12 cycles after start. The other takes a 56-bit key and a 64-bit block and finishes 16 cycles after start. Both run on the bridge clock. Software first writes a control register. Its fields pick the engine, the direction (encrypt or decrypt), whether data-register writes load key material or input data, and which 64-bit half of a 128-bit operand the next write fills. Software then writes words through the data register. The write that completes the operand starts the selected engine. The bridge tracks busy and done and captures the engine's output on the exact completion edge. Software reads the captured result through a result register, one 64-bit half at a time.

The port has no privilege input and raises no fault, so every access is accepted. The cipher datapaths are outside the block. The bridge drives each engine's key, block, direction and start, and samples the engine's result input.

The sequencer has four states. `ST_IDLE` waits for an operand. `ST_LAUNCH` is the single cycle in which the start pulse is driven. `ST_WAIT` counts to the engine's latency. `ST_DONE` holds a result that has not yet been read. Its transitions are as follows:
- IDLE to LAUNCH on a completing data write.
- LAUNCH to WAIT unconditionally.
- WAIT to DONE when the count reaches the latency.
- DONE to LAUNCH on a new completing data write.
- DONE to IDLE on a result read.

Top module: `msr_crypto_bridge`

## Requirements
- R1: After reset, the control register reads 0 with busy, done and error clear. The result register reads 0, all engine key and block outputs are 0, and neither start output is high.
- R2: Register addresses are: 0 for control/status, 1 for data and 2 for result. The control register bits, which read back as written, are:
  - bit 0: engine select (0 for the 128-bit engine, 1 for the 64-bit engine).
  - bit 1: direction (1 means decrypt).
  - bit 2: operand kind (1 means key, 0 means data).
  - bit 3: half select (1 means the upper 64 bits).
- R3: For the 128-bit engine, a data-register write stores the word into the key (kind=1) or block (kind=0) half chosen by bit 3. A block write to the lower half does not start the engine. A block write to the upper half does start it.
- R4: For the 64-bit engine, a key write keeps the low 56 bits of the word and drops bits 63:56. A block write stores the word and starts the engine whatever bit 3 holds.
- R5: The start output of the selected engine is high for exactly one cycle, the cycle after the starting write. The other engine's start stays low. The direction output equals bit 1 as it was at the start.
- R6: Status bit 8 (busy) is 1 from the start cycle until the completion edge and 0 afterwards.
- R7: The bridge samples the 128-bit engine's result on the 12th rising edge after the start cycle and the 64-bit engine's on the 16th. Status bit 9 (done) rises on that same edge. A result read returns the 64-bit half picked by bit 3, and the upper half is 0 for the 64-bit engine. The stored result changes only on a completion edge.
- R8: A data-register write while busy is ignored: operands are unchanged and the run is neither restarted nor delayed. The write sets the sticky error bit, status bit 10. Writing the control register with bit 10 set clears the error.
- R9: The first read of the result register clears done. The stored result stays readable.
- R10: Address 3 reads 0. Writes to address 3 or to the result register change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msr_wr | input | 1 | Register write strobe |
| msr_rd | input | 1 | Register read strobe |
| msr_addr | input | 2 | Register index |
| msr_wdata | input | 64 | Write data |
| msr_rdata | output | 64 | Read data for the addressed register (combinational) |
| wide_start | output | 1 | Start pulse to the 128-bit engine |
| wide_dec | output | 1 | Direction to the 128-bit engine, 1 = decrypt |
| wide_key | output | 128 | Key to the 128-bit engine |
| wide_blk | output | 128 | Input block to the 128-bit engine |
| wide_res | input | 128 | Result from the 128-bit engine |
| nar_start | output | 1 | Start pulse to the 64-bit engine |
| nar_dec | output | 1 | Direction to the 64-bit engine, 1 = decrypt |
| nar_key | output | 56 | Key to the 64-bit engine |
| nar_blk | output | 64 | Input block to the 64-bit engine |
| nar_res | input | 64 | Result from the 64-bit engine |

## Verification
A miscounted latency shows at the ports at once. The bench engines present a valid result only during the single cycle before the expected completion edge, so a capture one cycle early or late returns a garbage pattern on the first result read. Done also rises on the wrong polled cycle. Corrupted operand storage shows on the engine key and block outputs in the cycle after the write. A sequencer stuck in the wrong state shows within one cycle as a missing, repeated or misrouted start pulse, or as a busy or done bit that disagrees with the cycle count since start.

// File: rtl/msrcb_pkg.sv
package msrcb_pkg;

    localparam int ADDR_CTRL = 0;
    localparam int ADDR_DATA = 1;
    localparam int ADDR_RES  = 2;

    localparam int CB_ENG  = 0;
    localparam int CB_DEC  = 1;
    localparam int CB_KEY  = 2;
    localparam int CB_HALF = 3;

    localparam int SB_BUSY = 8;
    localparam int SB_DONE = 9;
    localparam int SB_ERR  = 10;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_WAIT   = 2'd2,
        ST_DONE   = 2'd3
    } seq_state_e;

    typedef enum logic {
        ENG_WIDE   = 1'b0,
        ENG_NARROW = 1'b1
    } eng_e;

    typedef struct packed {
        eng_e eng;
        logic dec;
        logic key_sel;
    } ctl_t;

endpackage

// File: rtl/msrcb_ctrl.sv
module msrcb_ctrl
    import msrcb_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int WORD_W = 64,
    parameter int HSEL_W = 1,
    parameter int RES_W  = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msr_wr,
    input  logic              msr_rd,
    input  logic [ADDR_W-1:0] msr_addr,
    input  logic              w_eng,
    input  logic              w_dec,
    input  logic              w_key,
    input  logic [HSEL_W-1:0] w_half,
    input  logic              w_errclr,
    input  logic              busy,
    input  logic              done,
    input  logic [RES_W-1:0]  res_q,
    output ctl_t              ctl,
    output logic [HSEL_W-1:0] half_idx,
    output logic              data_wr,
    output logic              res_rd,
    output logic              err,
    output logic [WORD_W-1:0] msr_rdata
);

    logic wr_ctrl;
    logic wr_data;

    assign wr_ctrl = msr_wr && (msr_addr == ADDR_W'(ADDR_CTRL));
    assign wr_data = msr_wr && (msr_addr == ADDR_W'(ADDR_DATA));
    assign data_wr = wr_data && !busy;
    assign res_rd  = msr_rd && (msr_addr == ADDR_W'(ADDR_RES));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl      <= '0;
            half_idx <= '0;
            err      <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctl.eng     <= eng_e'(w_eng);
                ctl.dec     <= w_dec;
                ctl.key_sel <= w_key;
                half_idx    <= w_half;
                if (w_errclr) begin
                    err <= 1'b0;
                end
            end
            if (wr_data && busy) begin
                err <= 1'b1;
            end
        end
    end

    always_comb begin
        msr_rdata = '0;
        unique case (msr_addr)
            ADDR_W'(ADDR_CTRL): begin
                msr_rdata[CB_ENG]              = ctl.eng;
                msr_rdata[CB_DEC]              = ctl.dec;
                msr_rdata[CB_KEY]              = ctl.key_sel;
                msr_rdata[CB_HALF +: HSEL_W]   = half_idx;
                msr_rdata[SB_BUSY]             = busy;
                msr_rdata[SB_DONE]             = done;
                msr_rdata[SB_ERR]              = err;
            end
            ADDR_W'(ADDR_RES): begin
                msr_rdata = res_q[int'(half_idx)*WORD_W +: WORD_W];
            end
            default: begin
                msr_rdata = '0;
            end
        endcase
    end

endmodule

// File: rtl/msrcb_operand.sv
module msrcb_operand
    import msrcb_pkg::*;
#(
    parameter int WORD_W = 64,
    parameter int WIDE_W = 128,
    parameter int NKEY_W = 56,
    parameter int NBLK_W = 64,
    parameter int HSEL_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_wr,
    input  ctl_t              ctl,
    input  logic [HSEL_W-1:0] half_idx,
    input  logic [WORD_W-1:0] wdata,
    output logic [WIDE_W-1:0] wide_key,
    output logic [WIDE_W-1:0] wide_blk,
    output logic [NKEY_W-1:0] nar_key,
    output logic [NBLK_W-1:0] nar_blk,
    output logic              launch
);

    localparam int NHALF = WIDE_W / WORD_W;
    localparam int LAST  = NHALF - 1;

    logic wide_sel;
    logic nar_sel;

    assign wide_sel = data_wr && (ctl.eng == ENG_WIDE);
    assign nar_sel  = data_wr && (ctl.eng == ENG_NARROW);

    for (genvar h = 0; h < NHALF; h++) begin : g_half
        logic [WORD_W-1:0] key_h;
        logic [WORD_W-1:0] blk_h;
        logic              hit;

        assign hit = wide_sel && (half_idx == HSEL_W'(h));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                key_h <= '0;
                blk_h <= '0;
            end else if (hit) begin
                if (ctl.key_sel) begin
                    key_h <= wdata;
                end else begin
                    blk_h <= wdata;
                end
            end
        end

        assign wide_key[h*WORD_W +: WORD_W] = key_h;
        assign wide_blk[h*WORD_W +: WORD_W] = blk_h;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nar_key <= '0;
            nar_blk <= '0;
        end else if (nar_sel) begin
            if (ctl.key_sel) begin
                nar_key <= wdata[NKEY_W-1:0];
            end else begin
                nar_blk <= wdata[NBLK_W-1:0];
            end
        end
    end

    assign launch = data_wr && !ctl.key_sel &&
                    ((ctl.eng == ENG_NARROW) || (half_idx == HSEL_W'(LAST)));

endmodule

// File: rtl/msrcb_seq.sv
module msrcb_seq
    import msrcb_pkg::*;
#(
    parameter int WIDE_W   = 128,
    parameter int NBLK_W   = 64,
    parameter int WIDE_LAT = 12,
    parameter int NAR_LAT  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  eng_e              launch_eng,
    input  logic              launch_dec,
    input  logic              res_rd,
    input  logic [WIDE_W-1:0] wide_res,
    input  logic [NBLK_W-1:0] nar_res,
    output logic              wide_start,
    output logic              nar_start,
    output logic              eng_dec,
    output logic              busy,
    output logic              done,
    output logic [WIDE_W-1:0] res_q
);

    localparam int LAT_MAX = (WIDE_LAT > NAR_LAT) ? WIDE_LAT : NAR_LAT;
    localparam int CNT_W   = (LAT_MAX > 2) ? $clog2(LAT_MAX) : 1;

    seq_state_e       state;
    seq_state_e       nxt;
    eng_e             run_eng;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] tgt;
    logic             finish;

    assign tgt    = (run_eng == ENG_WIDE) ? CNT_W'(WIDE_LAT - 1) : CNT_W'(NAR_LAT - 1);
    assign finish = (state == ST_WAIT) && (cnt == tgt);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (launch) nxt = ST_LAUNCH;
            end
            ST_LAUNCH: begin
                nxt = ST_WAIT;
            end
            ST_WAIT: begin
                if (finish) nxt = ST_DONE;
            end
            ST_DONE: begin
                if (launch)      nxt = ST_LAUNCH;
                else if (res_rd) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_eng <= ENG_WIDE;
            eng_dec <= 1'b0;
            cnt     <= '0;
            res_q   <= '0;
        end else begin
            if (launch) begin
                run_eng <= launch_eng;
                eng_dec <= launch_dec;
                cnt     <= '0;
            end else if (state == ST_LAUNCH || state == ST_WAIT) begin
                cnt <= cnt + 1'b1;
            end
            if (finish) begin
                if (run_eng == ENG_WIDE) begin
                    res_q <= wide_res;
                end else begin
                    res_q <= {{(WIDE_W-NBLK_W){1'b0}}, nar_res};
                end
            end
        end
    end

    assign busy       = (state == ST_LAUNCH) || (state == ST_WAIT);
    assign done       = (state == ST_DONE);
    assign wide_start = (state == ST_LAUNCH) && (run_eng == ENG_WIDE);
    assign nar_start  = (state == ST_LAUNCH) && (run_eng == ENG_NARROW);

endmodule

// File: rtl/msr_crypto_bridge.sv
module msr_crypto_bridge
    import msrcb_pkg::*;
#(
    parameter int ADDR_W   = 2,
    parameter int WORD_W   = 64,
    parameter int WIDE_W   = 128,
    parameter int NKEY_W   = 56,
    parameter int NBLK_W   = 64,
    parameter int WIDE_LAT = 12,
    parameter int NAR_LAT  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msr_wr,
    input  logic              msr_rd,
    input  logic [ADDR_W-1:0] msr_addr,
    input  logic [WORD_W-1:0] msr_wdata,
    output logic [WORD_W-1:0] msr_rdata,
    output logic              wide_start,
    output logic              wide_dec,
    output logic [WIDE_W-1:0] wide_key,
    output logic [WIDE_W-1:0] wide_blk,
    input  logic [WIDE_W-1:0] wide_res,
    output logic              nar_start,
    output logic              nar_dec,
    output logic [NKEY_W-1:0] nar_key,
    output logic [NBLK_W-1:0] nar_blk,
    input  logic [NBLK_W-1:0] nar_res
);

    localparam int NHALF  = WIDE_W / WORD_W;
    localparam int HSEL_W = (NHALF > 1) ? $clog2(NHALF) : 1;

    ctl_t              ctl;
    logic [HSEL_W-1:0] half_idx;
    logic              data_wr;
    logic              res_rd;
    logic              err;
    logic              busy;
    logic              done;
    logic              launch;
    logic              eng_dec;
    logic [WIDE_W-1:0] res_q;

    msrcb_ctrl #(
        .ADDR_W (ADDR_W),
        .WORD_W (WORD_W),
        .HSEL_W (HSEL_W),
        .RES_W  (WIDE_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .msr_wr    (msr_wr),
        .msr_rd    (msr_rd),
        .msr_addr  (msr_addr),
        .w_eng     (msr_wdata[CB_ENG]),
        .w_dec     (msr_wdata[CB_DEC]),
        .w_key     (msr_wdata[CB_KEY]),
        .w_half    (msr_wdata[CB_HALF +: HSEL_W]),
        .w_errclr  (msr_wdata[SB_ERR]),
        .busy      (busy),
        .done      (done),
        .res_q     (res_q),
        .ctl       (ctl),
        .half_idx  (half_idx),
        .data_wr   (data_wr),
        .res_rd    (res_rd),
        .err       (err),
        .msr_rdata (msr_rdata)
    );

    msrcb_operand #(
        .WORD_W (WORD_W),
        .WIDE_W (WIDE_W),
        .NKEY_W (NKEY_W),
        .NBLK_W (NBLK_W),
        .HSEL_W (HSEL_W)
    ) u_operand (
        .clk      (clk),
        .rst_n    (rst_n),
        .data_wr  (data_wr),
        .ctl      (ctl),
        .half_idx (half_idx),
        .wdata    (msr_wdata),
        .wide_key (wide_key),
        .wide_blk (wide_blk),
        .nar_key  (nar_key),
        .nar_blk  (nar_blk),
        .launch   (launch)
    );

    msrcb_seq #(
        .WIDE_W   (WIDE_W),
        .NBLK_W   (NBLK_W),
        .WIDE_LAT (WIDE_LAT),
        .NAR_LAT  (NAR_LAT)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch),
        .launch_eng (ctl.eng),
        .launch_dec (ctl.dec),
        .res_rd     (res_rd),
        .wide_res   (wide_res),
        .nar_res    (nar_res),
        .wide_start (wide_start),
        .nar_start  (nar_start),
        .eng_dec    (eng_dec),
        .busy       (busy),
        .done       (done),
        .res_q      (res_q)
    );

    assign wide_dec = eng_dec;
    assign nar_dec  = eng_dec;

endmodule

// File: rtl/msrcb_chk.sv
module msrcb_chk
    import msrcb_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int WIDE_W = 128,
    parameter int NKEY_W = 56,
    parameter int NBLK_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              msr_wr,
    input logic              msr_rd,
    input logic [ADDR_W-1:0] msr_addr,
    input logic              wide_start,
    input logic              nar_start,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic [WIDE_W-1:0] res_q,
    input logic [WIDE_W-1:0] wide_key,
    input logic [WIDE_W-1:0] wide_blk,
    input logic [NKEY_W-1:0] nar_key,
    input logic [NBLK_W-1:0] nar_blk
);

    logic data_hit;
    logic res_hit;
    logic any_start;

    assign data_hit  = msr_wr && (msr_addr == ADDR_W'(ADDR_DATA));
    assign res_hit   = msr_rd && (msr_addr == ADDR_W'(ADDR_RES));
    assign any_start = wide_start || nar_start;

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        any_start |=> !any_start);

    a_r5_one_engine: assert property (@(posedge clk) disable iff (!rst_n)
        wide_start |-> !nar_start);

    a_r5_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        any_start |-> $past(data_hit));

    a_r6_busy_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        any_start |-> busy);

    a_r8_err_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && data_hit) |=> err);

    a_r8_operands_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && data_hit) |=> ($stable(wide_key) && $stable(wide_blk) &&
                                $stable(nar_key) && $stable(nar_blk)));

    a_r7_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(res_q));

    a_r7_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

    a_r9_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (done && res_hit && !msr_wr) |=> !done);

endmodule

bind msr_crypto_bridge msrcb_chk #(
    .ADDR_W (ADDR_W),
    .WIDE_W (WIDE_W),
    .NKEY_W (NKEY_W),
    .NBLK_W (NBLK_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .msr_wr     (msr_wr),
    .msr_rd     (msr_rd),
    .msr_addr   (msr_addr),
    .wide_start (wide_start),
    .nar_start  (nar_start),
    .busy       (busy),
    .done       (done),
    .err        (err),
    .res_q      (res_q),
    .wide_key   (wide_key),
    .wide_blk   (wide_blk),
    .nar_key    (nar_key),
    .nar_blk    (nar_blk)
);

// File: tb/msr_crypto_bridge_tb.sv
`timescale 1ns/1ps
module msr_crypto_bridge_tb;

    localparam int WL = 12;
    localparam int NL = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         msr_wr = 1'b0;
    logic         msr_rd = 1'b0;
    logic [1:0]   msr_addr = '0;
    logic [63:0]  msr_wdata = '0;
    logic [63:0]  msr_rdata;
    logic         wide_start, wide_dec, nar_start, nar_dec;
    logic [127:0] wide_key, wide_blk, wide_res;
    logic [55:0]  nar_key;
    logic [63:0]  nar_blk, nar_res;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    always #4 clk = ~clk;

    msr_crypto_bridge u_dut (
        .clk(clk), .rst_n(rst_n), .msr_wr(msr_wr), .msr_rd(msr_rd),
        .msr_addr(msr_addr), .msr_wdata(msr_wdata), .msr_rdata(msr_rdata),
        .wide_start(wide_start), .wide_dec(wide_dec), .wide_key(wide_key),
        .wide_blk(wide_blk), .wide_res(wide_res),
        .nar_start(nar_start), .nar_dec(nar_dec), .nar_key(nar_key),
        .nar_blk(nar_blk), .nar_res(nar_res)
    );

    function automatic logic [127:0] f_wide(logic [127:0] k, logic [127:0] b, logic d);
        return d ? ~(b ^ k) : (b ^ {k[63:0], k[127:64]});
    endfunction

    function automatic logic [63:0] f_nar(logic [55:0] k, logic [63:0] b, logic d);
        return d ? ~(b ^ {8'h00, k}) : (b + {8'h00, k});
    endfunction

    // Engine stubs: output is valid only in the cycle before the expected capture edge
    int wcnt = 0;
    int ncnt = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            wcnt <= 0;
            ncnt <= 0;
        end else begin
            if (wide_start) wcnt <= WL - 1;
            else if (wcnt != 0) wcnt <= wcnt - 1;
            if (nar_start) ncnt <= NL - 1;
            else if (ncnt != 0) ncnt <= ncnt - 1;
        end
    end
    always_comb begin
        wide_res = (wcnt == 1) ? f_wide(wide_key, wide_blk, wide_dec) : {4{32'hDEADBEEF}};
        nar_res  = (ncnt == 1) ? f_nar(nar_key, nar_blk, nar_dec) : {2{32'hFEEDFACE}};
    end

    task automatic chk(input string tag, input logic [127:0] got, input logic [127:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [63:0] d);
        msr_wr = 1'b1; msr_addr = a; msr_wdata = d;
        @(negedge clk);
        msr_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [63:0] d);
        msr_rd = 1'b1; msr_addr = a;
        #1 d = msr_rdata;
        @(negedge clk);
        msr_rd = 1'b0;
    endtask

    function automatic logic [63:0] cw(logic e, logic d, logic k, logic h);
        return {60'd0, h, k, d, e};
    endfunction

    task automatic run_op(input logic eng, input logic dec, input logic [127:0] key,
                          input logic [127:0] blk, input bit poke);
        logic [63:0]  r;
        logic [127:0] exp;
        int           lat;
        lat = eng ? NL : WL;
        exp = eng ? {64'd0, f_nar(key[55:0], blk[63:0], dec)} : f_wide(key, blk, dec);
        if (!eng) begin
            wr(0, cw(0, dec, 1, 0)); wr(1, key[63:0]);
            wr(0, cw(0, dec, 1, 1)); wr(1, key[127:64]);
            chk("R3 wide key assembled", wide_key, key);
            wr(0, cw(0, dec, 0, 0)); wr(1, blk[63:0]);
            chk("R3 low half no start", {127'd0, wide_start}, 128'd0);
            rd(0, r);
            chk("R3 not busy after low half", {127'd0, r[8]}, 128'd0);
            wr(0, cw(0, dec, 0, 1)); wr(1, blk[127:64]);
            chk("R3 wide block assembled", wide_blk, blk);
        end else begin
            wr(0, cw(1, dec, 1, ~dec)); wr(1, key[63:0]);
            chk("R4 narrow key low 56 bits", {72'd0, nar_key}, {72'd0, key[55:0]});
            wr(0, cw(1, dec, 0, dec)); wr(1, blk[63:0]);
            chk("R4 narrow block", {64'd0, nar_blk}, {64'd0, blk[63:0]});
        end
        chk("R5 selected start", {127'd0, eng ? nar_start : wide_start}, 128'd1);
        chk("R5 other start low", {127'd0, eng ? wide_start : nar_start}, 128'd0);
        chk("R5 direction", {127'd0, eng ? nar_dec : wide_dec}, {127'd0, dec});
        for (int k = 0; k <= lat; k++) begin
            if (poke && k == 3) begin
                msr_wr = 1'b1; msr_addr = 2'd1; msr_wdata = ~blk[63:0];
            end else begin
                msr_rd = 1'b1; msr_addr = 2'd0;
                #1;
                chk("R6 busy window", {127'd0, msr_rdata[8]}, {127'd0, k < lat});
                chk("R7 done edge", {127'd0, msr_rdata[9]}, {127'd0, k == lat});
                if (k > 0) chk("R5 pulse one cycle", {127'd0, wide_start | nar_start}, 128'd0);
            end
            @(negedge clk);
            msr_wr = 1'b0; msr_rd = 1'b0;
        end
        rd(0, r);
        chk("R8 error flag", {127'd0, r[10]}, {127'd0, poke});
        if (poke) begin
            if (eng) chk("R8 narrow block kept", {64'd0, nar_blk}, {64'd0, blk[63:0]});
            else     chk("R8 wide block kept", wide_blk, blk);
            wr(0, cw(eng, dec, 0, 0) | 64'h400);
            rd(0, r);
            chk("R8 error cleared", {127'd0, r[10]}, 128'd0);
        end
        wr(0, cw(eng, dec, 0, 0));
        rd(2, r);
        chk("R7 result low", {64'd0, r}, {64'd0, exp[63:0]});
        rd(0, r);
        chk("R9 done cleared by read", {127'd0, r[9]}, 128'd0);
        wr(0, cw(eng, dec, 0, 1));
        rd(2, r);
        chk("R7 result high", {64'd0, r}, {64'd0, exp[127:64]});
        wr(0, cw(eng, dec, 0, 0));
        rd(2, r);
        chk("R9 result retained", {64'd0, r}, {64'd0, exp[63:0]});
    endtask

    initial begin
        logic [63:0]  r;
        logic [127:0] key, blk;
        repeat (3) @(negedge clk);
        // R1 reset state
        rd(0, r); chk("R1 ctrl after reset", {64'd0, r}, 128'd0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(0, r); chk("R1 ctrl/status zero", {64'd0, r}, 128'd0);
        rd(2, r); chk("R1 result zero", {64'd0, r}, 128'd0);
        chk("R1 wide operands zero", wide_key | wide_blk, 128'd0);
        chk("R1 narrow operands zero", {8'd0, nar_key, nar_blk}, 128'd0);
        chk("R1 no start", {126'd0, wide_start, nar_start}, 128'd0);
        // R2 control readback
        wr(0, 64'hF); rd(0, r);
        chk("R2 control readback", {64'd0, r}, 128'hF);
        wr(0, 64'h5); rd(0, r);
        chk("R2 control readback 2", {64'd0, r}, 128'h5);
        // Sweep: engine x direction x operand pattern
        for (int e = 0; e < 2; e++) begin
            for (int d = 0; d < 2; d++) begin
                for (int p = 0; p < 3; p++) begin
                    if (p == 0) key = '0;
                    else if (p == 1) key = 128'hF1E2D3C4B5A69788_0123456789ABCDEF ^ {16{8'(8'h11 * (e + 2*d + 1))}};
                    else key = '1;
                    blk = (p == 1) ? {key[40:0], key[127:41]} ^ 128'h5A : (p == 2 ? 128'd0 : '1);
                    run_op(e[0], d[0], key, blk, p == 1);
                end
            end
        end
        // R10 unused address and read-only result register
        wr(0, cw(1, 0, 0, 0));
        rd(2, r);
        key = {64'd0, r};
        wr(3, '1);
        wr(2, '1);
        rd(3, r); chk("R10 address 3 reads zero", {64'd0, r}, 128'd0);
        rd(0, r); chk("R10 control unchanged", {64'd0, r}, {64'd0, cw(1, 0, 0, 0)});
        rd(2, r); chk("R10 result unchanged", {64'd0, r}, key);
        chk("R10 no start", {126'd0, wide_start, nar_start}, 128'd0);
        if (!ended) begin
            ended = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            checks++;
            fails++;
            $display("FAIL watchdog got=timeout exp=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule